// File: doc/BRIEF.md
# Flash Status Flag Generator

This block forms the byte returned on a read while a NOR-style flash array runs an internal program or erase. A separate sequencer supplies the operating mode, the program data bit, a pulse-limit flag and the erase-complete and reset-command events. The block answers with a status byte that carries two toggle bits, a sticky timeout flag and an erase-window flag. In idle, and for reads outside the suspended sectors during an erase-suspend read, it passes array data through unchanged.

It also owns the erase set. Each accepted sector-erase command marks its sector and restarts a window counter. Once the counter runs out, the window closes and the erase is committed. After that, further sector-erase commands are ignored until the erase completes or a reset command arrives.

Top module: `flash_status_gen`

## Requirements
- R1: With mode idle (0), `rd_data_o` equals `array_data_i`.
- R2: Status byte bit 7 is the inverse of `prog_bit_i` in program (1) and suspend-program (4) modes, and 0 in erase mode (2).
- R3: Status bit 6 holds a toggle that flips after each strobed read in program, erase and suspend-program modes. It holds still on reads in suspend-read mode (3).
- R4: Status bit 2 holds a toggle that flips after each strobed read addressing a sector in the erase set, in erase, suspend-read and suspend-program modes. Reads of sectors outside the set do not flip it. The sector is `rd_addr_i[ADDR_W-1 -: SECT_W]`.
- R5: In suspend-program mode, a read of a sector outside the erase set shows bit 2 = 1.
- R6: In suspend-read mode, a read of a sector outside the erase set returns array data. A read inside the set returns the status byte.
- R7: Status bit 5 becomes 1 on the clock after `pulse_limit_i` and stays 1 until `reset_cmd_i`, which clears it on the next clock.
- R8: While bit 5 is 1, bits 3 and 2 read 0, bit 2 stops toggling, and bits 7 and 6 keep their normal behaviour.
- R9: Status bit 3 reads 0 while the erase window is open. It reads 1 from the WIN_CYCLES-th clock after the last accepted sector-erase command.
- R10: A sector-erase command is accepted while bit 3 is 0. Acceptance adds the sector to `erase_sectors_o` and restarts the window. While bit 3 is 1, commands are refused and `erase_sectors_o` does not change.
- R11: `erase_done_i` or `reset_cmd_i` empties the erase set and reopens command acceptance on the next clock.
- R12: Status bits 4, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | 0 idle, 1 program, 2 erase, 3 suspend-read, 4 suspend-program |
| prog_bit_i | input | 1 | Bit 7 of the byte being programmed |
| pulse_limit_i | input | 1 | Internal pulse count exceeded |
| reset_cmd_i | input | 1 | Reset command received |
| erase_done_i | input | 1 | Internal erase finished |
| se_cmd_i | input | 1 | Sector-erase command strobe |
| se_addr_i | input | ADDR_W | Address carried by the sector-erase command |
| rd_i | input | 1 | Read strobe, advances toggles |
| rd_addr_i | input | ADDR_W | Read address |
| array_data_i | input | 8 | Array data for pass-through reads |
| rd_data_o | output | 8 | Read data or status byte |
| se_accept_o | output | 1 | Sector-erase command taken this cycle |
| erase_sectors_o | output | NSECT | Current erase set |

## Verification
The bench targets the window edge. It checks bit 3 one cycle before and at the WIN_CYCLES-th clock, and it issues a second command just before expiry to show the restart. A counter off by one, or a window that does not reload, would move the edge it observes. It alternates reads between member and non-member sectors so that a bit 2 toggle that flips on every read, or never flips, shows up against the bench's own toggle model. It also holds the timeout across several idle cycles, which exposes a timeout flag that is not sticky or that still lets bits 2 and 3 through. Last, it separates the two suspend modes, where a design that mixed them would toggle bit 6 or return status in place of array data.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [2:0] {
    FM_IDLE    = 3'd0,
    FM_PROG    = 3'd1,
    FM_ERASE   = 3'd2,
    FM_SUSP_RD = 3'd3,
    FM_SUSP_PG = 3'd4
  } fmode_e;

  localparam int unsigned BIT_POLL = 7;
  localparam int unsigned BIT_TOG6 = 6;
  localparam int unsigned BIT_TMO  = 5;
  localparam int unsigned BIT_WIN  = 3;
  localparam int unsigned BIT_TOG2 = 2;
endpackage

// File: rtl/fsg_erase_window.sv
module fsg_erase_window #(
  parameter int unsigned NSECT      = 8,
  parameter int unsigned WIN_CYCLES = 16,
  localparam int unsigned SW = $clog2(NSECT),
  localparam int unsigned CW = $clog2(WIN_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             cmd_i,
  input  logic [SW-1:0]    sect_i,
  output logic             accept_o,
  output logic             closed_o,
  output logic [NSECT-1:0] set_o
);
  logic [NSECT-1:0] set_q, set_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             open_q, open_d;
  logic             closed_q, closed_d;

  assign accept_o = cmd_i & ~closed_q & ~clr_i;

  always_comb begin
    set_d    = set_q;
    cnt_d    = cnt_q;
    open_d   = open_q;
    closed_d = closed_q;
    if (clr_i) begin
      set_d    = '0;
      cnt_d    = '0;
      open_d   = 1'b0;
      closed_d = 1'b0;
    end else if (accept_o) begin
      set_d[sect_i] = 1'b1;
      cnt_d         = CW'(WIN_CYCLES);
      open_d        = 1'b1;
    end else if (open_q) begin
      if (cnt_q == CW'(1)) begin
        cnt_d    = '0;
        open_d   = 1'b0;
        closed_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q    <= '0;
      cnt_q    <= '0;
      open_q   <= 1'b0;
      closed_q <= 1'b0;
    end else begin
      set_q    <= set_d;
      cnt_q    <= cnt_d;
      open_q   <= open_d;
      closed_q <= closed_d;
    end
  end

  assign closed_o = closed_q;
  assign set_o    = set_q;
endmodule

// File: rtl/fsg_flags.sv
module fsg_flags
  import fsg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  fmode_e mode_i,
  input  logic   rd_i,
  input  logic   in_set_i,
  input  logic   limit_i,
  input  logic   rst_cmd_i,
  output logic   tog6_o,
  output logic   tog2_o,
  output logic   tmo_o
);
  logic tog6_q, tog6_d, tog2_q, tog2_d, tmo_q, tmo_d;
  logic en6, en2;

  always_comb begin
    en6 = rd_i && (mode_i == FM_PROG || mode_i == FM_ERASE || mode_i == FM_SUSP_PG);
    en2 = rd_i && in_set_i && !tmo_q &&
          (mode_i == FM_ERASE || mode_i == FM_SUSP_RD || mode_i == FM_SUSP_PG);
    tog6_d = en6 ? ~tog6_q : tog6_q;
    tog2_d = en2 ? ~tog2_q : tog2_q;
    if (rst_cmd_i)    tmo_d = 1'b0;
    else if (limit_i) tmo_d = 1'b1;
    else              tmo_d = tmo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog6_q <= 1'b0;
      tog2_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      tog6_q <= tog6_d;
      tog2_q <= tog2_d;
      tmo_q  <= tmo_d;
    end
  end

  assign tog6_o = tog6_q;
  assign tog2_o = tog2_q;
  assign tmo_o  = tmo_q;
endmodule

// File: rtl/fsg_rd_mux.sv
module fsg_rd_mux
  import fsg_pkg::*;
(
  input  fmode_e     mode_i,
  input  logic       in_set_i,
  input  logic       prog_bit_i,
  input  logic       tog6_i,
  input  logic       tog2_i,
  input  logic       tmo_i,
  input  logic       closed_i,
  input  logic [7:0] array_i,
  output logic [7:0] data_o
);
  logic [7:0] stat;
  logic       pass;

  always_comb begin
    stat = '0;
    stat[BIT_POLL] = (mode_i == FM_PROG || mode_i == FM_SUSP_PG) ? ~prog_bit_i : 1'b0;
    stat[BIT_TOG6] = tog6_i;
    stat[BIT_TMO]  = tmo_i;
    stat[BIT_WIN]  = tmo_i ? 1'b0 : closed_i;
    if (tmo_i)                                stat[BIT_TOG2] = 1'b0;
    else if (mode_i == FM_SUSP_PG && !in_set_i) stat[BIT_TOG2] = 1'b1;
    else                                      stat[BIT_TOG2] = tog2_i;
    pass = (mode_i == FM_IDLE) || (mode_i == FM_SUSP_RD && !in_set_i);
    data_o = pass ? array_i : stat;
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned SECT_W     = 3,
  parameter int unsigned WIN_CYCLES = 16,
  localparam int unsigned NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              prog_bit_i,
  input  logic              pulse_limit_i,
  input  logic              reset_cmd_i,
  input  logic              erase_done_i,
  input  logic              se_cmd_i,
  input  logic [ADDR_W-1:0] se_addr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        array_data_i,
  output logic [7:0]        rd_data_o,
  output logic              se_accept_o,
  output logic [NSECT-1:0]  erase_sectors_o
);
  import fsg_pkg::*;

  fmode_e            mode;
  logic [SECT_W-1:0] rd_sect, se_sect;
  logic              in_set, win_closed, clear;
  logic              tog6, tog2, tmo;

  assign mode    = fmode_e'(mode_i);
  assign rd_sect = rd_addr_i[ADDR_W-1 -: SECT_W];
  assign se_sect = se_addr_i[ADDR_W-1 -: SECT_W];
  assign clear   = erase_done_i | reset_cmd_i;
  assign in_set  = erase_sectors_o[rd_sect];

  fsg_erase_window #(.NSECT(NSECT), .WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk(clk), .rst_n(rst_n), .clr_i(clear), .cmd_i(se_cmd_i),
    .sect_i(se_sect), .accept_o(se_accept_o), .closed_o(win_closed),
    .set_o(erase_sectors_o)
  );

  fsg_flags u_flags (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .rd_i(rd_i), .in_set_i(in_set),
    .limit_i(pulse_limit_i), .rst_cmd_i(reset_cmd_i),
    .tog6_o(tog6), .tog2_o(tog2), .tmo_o(tmo)
  );

  fsg_rd_mux u_mux (
    .mode_i(mode), .in_set_i(in_set), .prog_bit_i(prog_bit_i),
    .tog6_i(tog6), .tog2_i(tog2), .tmo_i(tmo), .closed_i(win_closed),
    .array_i(array_data_i), .data_o(rd_data_o)
  );
endmodule

// File: rtl/fsg_chk.sv
module fsg_chk #(
  parameter int unsigned NSECT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode_i,
  input logic             rd_i,
  input logic             pulse_limit_i,
  input logic             reset_cmd_i,
  input logic             erase_done_i,
  input logic             se_cmd_i,
  input logic             se_accept_o,
  input logic [7:0]       array_data_i,
  input logic [7:0]       rd_data_o,
  input logic [NSECT-1:0] erase_sectors_o,
  input logic             in_set,
  input logic             win_closed,
  input logic             tog6,
  input logic             tmo
);
  // R7
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo && !reset_cmd_i |=> tmo);
  // R7
  tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_limit_i && !reset_cmd_i |=> tmo);
  // R10
  closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_closed && se_cmd_i && !erase_done_i && !reset_cmd_i |=> $stable(erase_sectors_o));
  // R9
  reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    se_accept_o |=> !win_closed && (erase_sectors_o != '0));
  // R1
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 3'd0 |-> rd_data_o == array_data_i);
  // R3
  susp_rd_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i && mode_i == 3'd3 |=> $stable(tog6));
  // R5
  susp_pg_dq2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 3'd4 && !in_set && !tmo |-> rd_data_o[2]);
  // R12
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i != 3'd0 && !(mode_i == 3'd3 && !in_set) |-> rd_data_o[4] == 1'b0 && rd_data_o[1:0] == 2'b00);
endmodule

bind flash_status_gen fsg_chk #(.NSECT(NSECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rd_i(rd_i),
  .pulse_limit_i(pulse_limit_i), .reset_cmd_i(reset_cmd_i),
  .erase_done_i(erase_done_i), .se_cmd_i(se_cmd_i), .se_accept_o(se_accept_o),
  .array_data_i(array_data_i), .rd_data_o(rd_data_o),
  .erase_sectors_o(erase_sectors_o), .in_set(in_set), .win_closed(win_closed),
  .tog6(tog6), .tmo(tmo)
);

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
  localparam int unsigned AW = 12, SW = 3, WIN = 16, NS = 1 << SW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode_i = '0;
  logic prog_bit_i = 1'b0, pulse_limit_i = 1'b0, reset_cmd_i = 1'b0, erase_done_i = 1'b0;
  logic se_cmd_i = 1'b0, rd_i = 1'b0;
  logic [AW-1:0] se_addr_i = '0, rd_addr_i = '0;
  logic [7:0] array_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic se_accept_o;
  logic [NS-1:0] erase_sectors_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic exp6 = 1'b0, exp2 = 1'b0, exp_tmo = 1'b0;
  logic [NS-1:0] exp_set = '0;

  always #2.5 clk = ~clk;

  flash_status_gen #(.ADDR_W(AW), .SECT_W(SW), .WIN_CYCLES(WIN)) u_dut (.*);

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  function automatic logic [AW-1:0] sa(input int s);
    return AW'(s) << (AW - SW);
  endfunction

  task automatic do_read(input int s, output logic [7:0] d);
    rd_addr_i = sa(s); rd_i = 1'b1; #1;
    d = rd_data_o;
    tick(1); rd_i = 1'b0;
    if (mode_i == 3'd1 || mode_i == 3'd2 || mode_i == 3'd4) exp6 = ~exp6;
    if (exp_set[s] && !exp_tmo && (mode_i == 3'd2 || mode_i == 3'd3 || mode_i == 3'd4)) exp2 = ~exp2;
  endtask

  task automatic peek(input int s, output logic [7:0] d);
    rd_addr_i = sa(s); #1; d = rd_data_o;
  endtask

  task automatic se_cmd(input int s, output logic acc);
    se_addr_i = sa(s); se_cmd_i = 1'b1; #1;
    acc = se_accept_o;
    tick(1); se_cmd_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    array_data_i = 8'hA5; mode_i = 3'd0;
    peek(1, d); check8("R1 idle passthrough", d, 8'hA5);
    check8("R11 empty set after reset", 8'(erase_sectors_o), 8'h00);
  endtask

  task automatic t_program();
    logic [7:0] d;
    mode_i = 3'd1; prog_bit_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      logic e6;
      e6 = exp6;
      do_read(0, d);
      check8("R3 R2 program status", d, {1'b0, e6, 6'b000000});
    end
    prog_bit_i = 1'b0;
    peek(0, d); check8("R2 inverted poll bit", d, {1'b1, exp6, 6'b000000});
    mode_i = 3'd0; array_data_i = 8'h3C;
    peek(0, d); check8("R1 true data after program", d, 8'h3C);
  endtask

  task automatic t_window();
    logic acc; logic [7:0] d;
    se_cmd(2, acc); exp_set[2] = 1'b1;
    check8("R10 first command accepted", {7'd0, acc}, 8'h01);
    mode_i = 3'd2;
    tick(WIN - 3);
    se_cmd(5, acc); exp_set[5] = 1'b1;
    check8("R10 restart command accepted", {7'd0, acc}, 8'h01);
    tick(WIN - 1);
    peek(0, d); check8("R9 window still open", d & 8'h08, 8'h00);
    tick(1);
    peek(0, d); check8("R9 window closed", d & 8'h08, 8'h08);
    se_cmd(6, acc);
    check8("R10 late command refused", {7'd0, acc}, 8'h00);
    check8("R10 set unchanged", 8'(erase_sectors_o), 8'b0010_0100);
  endtask

  task automatic t_dq2();
    logic [7:0] d; logic e2, e6;
    for (int i = 0; i < 2; i++) begin
      e2 = exp2; e6 = exp6;
      do_read(2, d);
      check8("R4 R2 erase member read", d, {1'b0, e6, 3'b001, e2, 2'b00});
    end
    e2 = exp2;
    do_read(6, d); check8("R4 non-member no toggle", d & 8'h04, {5'd0, e2, 2'b00});
    e2 = exp2;
    do_read(5, d); check8("R4 member after non-member", d & 8'h04, {5'd0, e2, 2'b00});
  endtask

  task automatic t_susp();
    logic [7:0] d; logic e2, e6;
    mode_i = 3'd3; array_data_i = 8'h5A;
    e6 = exp6;
    for (int i = 0; i < 2; i++) begin
      e2 = exp2;
      do_read(2, d);
      check8("R3 R4 suspend-read member", d, {1'b0, e6, 3'b001, e2, 2'b00});
    end
    peek(0, d); check8("R6 suspend-read outside set", d, 8'h5A);
    mode_i = 3'd4; prog_bit_i = 1'b1;
    e6 = exp6;
    do_read(0, d); check8("R5 suspend-program outside set", d, {1'b0, e6, 3'b001, 1'b1, 2'b00});
    peek(0, d); check8("R3 suspend-program toggles", d & 8'h40, {1'b0, ~e6, 6'd0});
  endtask

  task automatic t_timeout();
    logic [7:0] d; logic e6;
    mode_i = 3'd2; erase_done_i = 1'b1; tick(1); erase_done_i = 1'b0; exp_set = '0;
    check8("R11 set cleared", 8'(erase_sectors_o), 8'h00);
    peek(0, d); check8("R11 window reopened", d & 8'h08, 8'h00);
    mode_i = 3'd1; prog_bit_i = 1'b0;
    pulse_limit_i = 1'b1; tick(1); pulse_limit_i = 1'b0; exp_tmo = 1'b1;
    tick(4);
    for (int i = 0; i < 2; i++) begin
      e6 = exp6;
      do_read(3, d);
      check8("R7 R8 timed-out status", d, {1'b1, e6, 1'b1, 5'd0});
    end
    reset_cmd_i = 1'b1; tick(1); reset_cmd_i = 1'b0; exp_tmo = 1'b0;
    peek(3, d); check8("R7 cleared by reset", d & 8'h20, 8'h00);
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(1);
    t_reset();
    t_program();
    t_window();
    t_dq2();
    t_susp();
    t_timeout();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #100000;
        if (!done) begin
          n_chk++; n_fail++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule